// File: doc/BRIEF.md
# Per-Channel Power-Down Sequencer

This block tracks the power state of a bank of converter channels. Each channel has an active-low sleep request, and the master clock samples it on every edge. A channel falls asleep only after its request has been low on a minimum number of consecutive samples, so short glitches are filtered out. When the request returns high, the channel wakes at once. It then holds its data-ready flag low until it has counted a fixed number of conversion periods. That count is 130 when the output port runs in SPI mode and 129 when it runs in frame-sync mode.

Conversion periods arrive as a one-clock strobe from the converter's decimation timing, and the settling counters advance only on that strobe. Channels that wake on the same clock edge share the same strobes from then on, so they become ready together with no external synchronisation. A single restart pulse marks every edge on which at least one channel woke. When every channel is asleep, an all-down flag tells the rest of the chip that it may drop to its lowest power state.

No data stream passes through the block. Every pin is a plain level or strobe, and none has back-pressure.

Top module: `pwdn_sequencer`

## Requirements
- R1: A channel goes to sleep (`ch_active` bit low) in the cycle after the second of two consecutive clock samples with its `pd_req_n` bit low. A request that is low on only one sample, with high samples on both sides, leaves `ch_active` and `ch_ready` unchanged.
- R2: A sleeping channel whose `pd_req_n` bit is sampled high shows `ch_active` high in the next cycle, with `ch_ready` low.
- R3: `all_down` is high exactly in the cycles in which every `ch_active` bit is low. While it is high, every `ch_ready` bit is low.
- R4: With `mode_fs` = 0 (SPI), `ch_ready` of an awake channel rises in the cycle after the 130th counted `conv_stb`.
- R5: With `mode_fs` = 1 (frame-sync), `ch_ready` rises in the cycle after the 129th counted `conv_stb`.
- R6: A ready channel keeps `ch_ready` high until it is itself put to sleep. Sleeping or waking of other channels does not disturb it.
- R7: `restart_stb` is high for one cycle, in the same cycle in which one or more `ch_active` bits rise. Channels that wake on the same edge raise `ch_ready` in the same cycle.
- R8: A channel put to sleep during its settling count drops that count and keeps `ch_ready` low. On its next wake it runs the full count again.
- R9: During and after reset, all channels are awake with `ch_ready` low, `all_down` and `restart_stb` are low, and each channel runs the full settling count before it becomes ready.
- R10: A `conv_stb` counts for a channel only when it is sampled in a cycle in which that channel shows `ch_active` high and `ch_ready` low. Clock cycles without the strobe never advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | N_CH | Per-channel sleep request, active low |
| conv_stb | input | 1 | One-cycle pulse per conversion period |
| mode_fs | input | 1 | Output-port mode: 0 SPI, 1 frame-sync |
| ch_active | output | N_CH | Channel is awake |
| ch_ready | output | N_CH | Channel data has settled |
| all_down | output | 1 | Every channel is asleep |
| restart_stb | output | 1 | One-cycle pulse on any wake |

## Verification
Every output comes straight from a register, so each result is due exactly one edge after the sample that causes it. The only exception is the entry into sleep, which needs two low samples and therefore shows on the cycle after the second of them. The bench drives inputs on the falling edge and keeps a cycle-level reference model that advances on the rising edge. It compares all four outputs on the next falling edge, which is after the registers have settled and before any new input is sampled. The directed settling checks count, one falling edge at a time, the strobes that meet the counting condition of R10 until `ch_ready` rises, so the 130 and 129 totals are exact and do not depend on when the counting starts.

// File: rtl/pwdn_seq_pkg.sv
package pwdn_seq_pkg;

  // Output-port mode that selects the settling length.
  typedef enum logic {
    IFM_SPI   = 1'b0,
    IFM_FSYNC = 1'b1
  } ifm_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/pd_req_filter.sv
// Minimum low-pulse filter for one channel's sleep request.
module pd_req_filter #(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic down_q,
  output logic down_d
);
  localparam int unsigned LW = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;
  localparam logic [LW-1:0] LIM = LW'(MIN_LOW - 1);

  logic [LW-1:0] low_cnt;
  logic [LW-1:0] low_nxt;

  // down_d is the state that the next edge will load.
  always_comb begin
    down_d  = !req_n && (down_q || (low_cnt == LIM));
    if (req_n)
      low_nxt = '0;
    else if (low_cnt == LIM)
      low_nxt = LIM;
    else
      low_nxt = low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      down_q  <= 1'b0;
    end else begin
      low_cnt <= low_nxt;
      down_q  <= down_d;
    end
  end
endmodule

// File: rtl/settle_timer.sv
// Counts conversion strobes after a wake-up and raises ready at the target.
module settle_timer #(
  parameter int unsigned SPI_SETTLE = 130,
  parameter int unsigned FS_SETTLE  = 129
) (
  input  logic clk,
  input  logic rst_n,
  input  logic down_q,
  input  logic down_d,
  input  logic conv_stb,
  input  logic mode_fs,
  output logic ready
);
  import pwdn_seq_pkg::*;

  localparam int unsigned MAXT = max_u(SPI_SETTLE, FS_SETTLE);
  localparam int unsigned CW   = bits_for(MAXT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] tgt;
  logic          counting;

  always_comb begin
    tgt      = (ifm_e'(mode_fs) == IFM_FSYNC) ? CW'(FS_SETTLE) : CW'(SPI_SETTLE);
    cnt_inc  = cnt + 1'b1;
    counting = !down_q && !ready && conv_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (down_d) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (counting) begin
      if (cnt_inc >= tgt) begin
        cnt   <= '0;
        ready <= 1'b1;
      end else begin
        cnt <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/restart_align.sv
// Shared restart pulse and all-channels-asleep flag.
module restart_align #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] down_q,
  input  logic [N_CH-1:0] down_d,
  output logic            restart_stb,
  output logic            all_down
);
  logic [N_CH-1:0] waking;

  always_comb begin
    waking   = down_q & ~down_d;
    all_down = &down_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_stb <= 1'b0;
    else        restart_stb <= |waking;
  end
endmodule

// File: rtl/pwdn_sequencer.sv
module pwdn_sequencer #(
  parameter int unsigned N_CH       = 8,
  parameter int unsigned MIN_LOW    = 2,
  parameter int unsigned SPI_SETTLE = 130,
  parameter int unsigned FS_SETTLE  = 129
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pd_req_n,
  input  logic            conv_stb,
  input  logic            mode_fs,
  output logic [N_CH-1:0] ch_active,
  output logic [N_CH-1:0] ch_ready,
  output logic            all_down,
  output logic            restart_stb
);
  logic [N_CH-1:0] down_q;
  logic [N_CH-1:0] down_d;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pd_req_filter #(
      .MIN_LOW(MIN_LOW)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .req_n (pd_req_n[g]),
      .down_q(down_q[g]),
      .down_d(down_d[g])
    );

    settle_timer #(
      .SPI_SETTLE(SPI_SETTLE),
      .FS_SETTLE (FS_SETTLE)
    ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .down_q  (down_q[g]),
      .down_d  (down_d[g]),
      .conv_stb(conv_stb),
      .mode_fs (mode_fs),
      .ready   (ch_ready[g])
    );
  end

  restart_align #(
    .N_CH(N_CH)
  ) u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .down_q     (down_q),
    .down_d     (down_d),
    .restart_stb(restart_stb),
    .all_down   (all_down)
  );

  assign ch_active = ~down_q;
endmodule

// File: rtl/pwdn_sequencer_chk.sv
module pwdn_sequencer_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] pd_req_n,
  input logic            conv_stb,
  input logic [N_CH-1:0] ch_active,
  input logic [N_CH-1:0] ch_ready,
  input logic            all_down,
  input logic            restart_stb
);
  for (genvar g = 0; g < N_CH; g++) begin : g_a
    AST_ENTER_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_active[g]) |-> (!$past(pd_req_n[g]) && !$past(pd_req_n[g], 2))); // R1
    AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_active[g]) |-> !ch_ready[g]); // R2
    AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_ready[g]) |-> !ch_active[g]); // R6
    AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_ready[g]) |-> $past(conv_stb)); // R10
  end

  AST_ALL_DOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    all_down |-> (ch_ready == '0)); // R3
  AST_RESTART_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    restart_stb == (|(ch_active & ~$past(ch_active)))); // R7
endmodule

bind pwdn_sequencer pwdn_sequencer_chk #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pd_req_n   (pd_req_n),
  .conv_stb   (conv_stb),
  .ch_active  (ch_active),
  .ch_ready   (ch_ready),
  .all_down   (all_down),
  .restart_stb(restart_stb)
);

// File: tb/pwdn_sequencer_tb.sv
module pwdn_sequencer_tb;
  localparam int N     = 8;
  localparam int SPI_T = 130;
  localparam int FS_T  = 129;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         stb = 1'b0;
  logic         mode = 1'b0;
  logic [N-1:0] ch_active;
  logic [N-1:0] ch_ready;
  logic         all_down;
  logic         restart_stb;

  int vec = 0;
  int mis = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  // reference model state
  int m_low [N];
  bit m_down[N];
  int m_cnt [N];
  bit m_rdy [N];
  bit m_rs;

  always #2 clk = ~clk;

  pwdn_sequencer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_req_n   (req_n),
    .conv_stb   (stb),
    .mode_fs    (mode),
    .ch_active  (ch_active),
    .ch_ready   (ch_ready),
    .all_down   (all_down),
    .restart_stb(restart_stb)
  );

  function automatic int settle_len(input logic fs);
    return fs ? FS_T : SPI_T;
  endfunction

  function automatic logic [N-1:0] exp_active();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = !m_down[i];
    return v;
  endfunction

  function automatic logic [N-1:0] exp_ready();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_rdy[i];
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // model advances on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    bit nd;
    bit any;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_low[i] = 0; m_down[i] = 0; m_cnt[i] = 0; m_rdy[i] = 0;
      end
      m_rs = 0;
    end else begin
      any = 0;
      for (int i = 0; i < N; i++) begin
        nd = !req_n[i] && (m_down[i] || m_low[i] >= 1);
        m_low[i] = req_n[i] ? 0 : 1;
        if (nd) begin
          m_cnt[i] = 0; m_rdy[i] = 0;
        end else if (!m_down[i] && !m_rdy[i] && stb) begin
          m_cnt[i]++;
          if (m_cnt[i] >= settle_len(mode)) begin
            m_rdy[i] = 1; m_cnt[i] = 0;
          end
        end
        if (m_down[i] && !nd) any = 1;
        m_down[i] = nd;
      end
      m_rs = any;
    end
  end

  // cycle-by-cycle comparison away from the sampling edge
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      bit all_dn;
      all_dn = 1;
      for (int i = 0; i < N; i++) if (!m_down[i]) all_dn = 0;
      chk("R1,R2", "ch_active", 32'(ch_active), 32'(exp_active()));
      chk("R4,R5,R6,R8,R10", "ch_ready", 32'(ch_ready), 32'(exp_ready()));
      chk("R3", "all_down", 32'(all_down), 32'(all_dn));
      chk("R7", "restart_stb", 32'(restart_stb), 32'(m_rs));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mis++;
      $display("FAIL R9 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end

  // counts strobes that the settling rule accepts until ready rises
  task automatic count_to_ready(input int ch, output int n);
    int guard;
    n = 0;
    guard = 0;
    while (!ch_ready[ch] && guard < 2000) begin
      if (ch_active[ch] && stb) n++;
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    int n;
    logic [N-1:0] level;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "active in reset", 32'(ch_active), 32'hFF);
    chk("R9", "ready in reset", 32'(ch_ready), 32'h0);
    chk("R9", "all_down in reset", 32'(all_down), 32'h0);
    chk("R9", "restart in reset", 32'(restart_stb), 32'h0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk("R9", "active after reset", 32'(ch_active), 32'hFF);
    stb = 1'b1;
    count_to_ready(0, n);
    chk("R4,R9", "strobes to ready after reset", 32'(n), 32'(SPI_T));
    chk("R7", "all ready together", 32'(ch_ready), 32'hFF);

    // R1 single-sample glitch ignored
    req_n[1] = 1'b0;
    @(negedge clk);
    req_n[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "glitch active", 32'(ch_active[1]), 32'h1);
    chk("R1", "glitch ready", 32'(ch_ready), 32'hFF);

    // R1 two low samples enter sleep
    req_n[1] = 1'b0;
    @(negedge clk);
    chk("R1", "one low sample", 32'(ch_active[1]), 32'h1);
    @(negedge clk);
    chk("R1", "two low samples", 32'(ch_active[1]), 32'h0);
    chk("R6", "others stay ready", 32'(ch_ready), 32'hFD);
    req_n[2] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "two asleep", 32'(ch_active), 32'hF9);

    // R2 R5 R7 simultaneous wake in frame-sync mode
    mode = 1'b1;
    req_n[1] = 1'b1;
    req_n[2] = 1'b1;
    @(negedge clk);
    chk("R2", "woken active", 32'(ch_active), 32'hFF);
    chk("R2", "woken not ready", 32'(ch_ready[2:1]), 32'h0);
    chk("R7", "restart pulse", 32'(restart_stb), 32'h1);
    count_to_ready(1, n);
    chk("R5", "strobes to ready fsync", 32'(n), 32'(FS_T));
    chk("R7", "aligned ready", 32'(ch_ready[2]), 32'h1);
    chk("R7", "restart ended", 32'(restart_stb), 32'h0);
    mode = 1'b0;

    // R8 sleep during settling restarts the count
    req_n[3] = 1'b0;
    repeat (2) @(negedge clk);
    req_n[3] = 1'b1;
    repeat (51) @(negedge clk);
    req_n[3] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "asleep mid-count", 32'(ch_active[3]), 32'h0);
    chk("R8", "ready low mid-count", 32'(ch_ready[3]), 32'h0);
    req_n[3] = 1'b1;
    @(negedge clk);
    count_to_ready(3, n);
    chk("R8", "full count after re-sleep", 32'(n), 32'(SPI_T));

    // R10 no strobes, no progress
    stb = 1'b0;
    req_n[4] = 1'b0;
    repeat (2) @(negedge clk);
    req_n[4] = 1'b1;
    repeat (400) @(negedge clk);
    chk("R10", "no strobe no ready", 32'(ch_ready[4]), 32'h0);
    stb = 1'b1;
    count_to_ready(4, n);
    chk("R10", "strobes to ready", 32'(n), 32'(SPI_T));

    // R3 all asleep
    req_n = '0;
    repeat (2) @(negedge clk);
    chk("R3", "all_down set", 32'(all_down), 32'h1);
    chk("R3", "none ready", 32'(ch_ready), 32'h0);
    req_n[5] = 1'b1;
    @(negedge clk);
    chk("R3", "all_down cleared", 32'(all_down), 32'h0);
    req_n = '1;
    @(negedge clk);

    // constrained random phase against the model
    level = '1;
    for (int c = 0; c < 30000; c++) begin
      @(negedge clk);
      stb = 1'($urandom % 2);
      if (c % 5000 == 4999) mode = 1'($urandom % 2);
      for (int i = 0; i < N; i++) begin
        if ($urandom % 700 == 0) level[i] = ~level[i];
        req_n[i] = level[i] & !($urandom % 300 == 0);
      end
    end
    @(negedge clk);
    cmp_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule